// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This block holds two independent down-counting timers: a general-purpose timer and a real-time-clock timer. Each timer is a prescaler that divides the clock, feeding a counter that counts prescaler wraps. Both timers have their own prescaler and counter preset registers. The bus cannot read the single control word that drives both timers. Each timer owns one 4-bit field of that word. In each field, two bits are stored mode bits (enable, reload-at-zero). The other two are one-shot commands that copy a preset into the prescaler or the counter in the cycle of the write.

Software writes presets and the control word through a plain write strobe, address and data port. Because the control word cannot be read, every control write must restate the mode bits of the timer it does not mean to change. Each timer drives its live counter value and a tick output. The tick pulses for one clock each time the counter runs down from one to zero.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset both counters read 0, both ticks are low, and both timers are disabled with reload mode off.
- R2: Write address 0 is the control word. Address 1 is the general-purpose prescaler preset and address 2 is its counter preset. Address 3 is the real-time-clock prescaler preset and address 4 is its counter preset. Presets take the low bits of the write data. Writing a preset does not change a running count.
- R3: The general-purpose field is control bits 3:0 and the real-time-clock field is bits 11:8. Within a field, bit 0 is reload-at-zero, bit 1 loads the counter, bit 2 is enable and bit 3 loads the prescaler.
- R4: The timer counts while it is enabled and its counter is nonzero. The prescaler steps down once per clock and, on reaching zero, reloads its preset and steps the counter down by one. A write that loads prescaler preset S and counter preset P with enable set raises the tick on the P*(S+1)-th clock edge after the write edge.
- R5: The tick is high for one clock per count-out. It rises on the edge where the counter leaves the value 1, and it is never high unless the counter held 1 in the previous cycle.
- R6: With reload off, the counter stays at 0 after a count-out and no further tick occurs until a counter load.
- R7: With reload on, the counter takes its preset on the same edge that raises the tick, and count-outs repeat every P*(S+1) clocks.
- R8: With enable at 0, the prescaler and counter hold their values. Mode bits written in a control write take effect from the cycle after that write.
- R9: Load bits are not stored and act only on the write edge. A counter load overrides a decrement on that edge. A control write whose counter-load bit is 0 lets the count proceed normally.
- R10: Each control write updates both fields. The other timer keeps counting undisturbed when its mode bits are rewritten unchanged and its load bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DATA_W | Write data |
| gp_count | output | CNT_W | Live general-purpose counter value |
| rtc_count | output | CNT_W | Live real-time-clock counter value |
| gp_tick | output | 1 | General-purpose count-out pulse |
| rtc_tick | output | 1 | Real-time-clock count-out pulse |

## Verification
The bench builds the block with a 4-bit prescaler, an 8-bit counter and 16-bit write data. With these sizes, full count-out periods of a few dozen clocks can be measured edge by edge, and several reload periods fit in a short run. The 16-bit data width reaches both control fields, so a write aimed at one timer can be checked against the other timer's running count. A prescaler preset of zero makes the counter step on every edge, which exposes the exact edge on which a load overrides a decrement or a disable takes hold.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int NUM_TMR      = 2;
  localparam int FIELD_W      = 4;
  localparam int FIELD_STRIDE = 8;
  localparam int ADDR_W       = 3;

  // Field layout, MSB first: bit3 prescaler load, bit2 enable,
  // bit1 counter load, bit0 reload-at-zero.
  typedef struct packed {
    logic ld_ps;
    logic en;
    logic ld_cnt;
    logic rld;
  } field_t;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
endpackage

// File: rtl/dtt_rst_sync.sv
module dtt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/dtt_regfile.sv
module dtt_regfile
  import dtt_pkg::*;
#(
  parameter int PS_W   = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NUM_TMR-1:0][PS_W-1:0]   ps_pre,
  output logic [NUM_TMR-1:0][CNT_W-1:0]  cnt_pre,
  output logic [NUM_TMR-1:0]             mode_en,
  output logic [NUM_TMR-1:0]             mode_rld,
  output logic [NUM_TMR-1:0]             cmd_ld_ps,
  output logic [NUM_TMR-1:0]             cmd_ld_cnt
);
  logic [NUM_TMR-1:0][PS_W-1:0]  ps_q,  ps_d;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [NUM_TMR-1:0]            en_q,  en_d;
  logic [NUM_TMR-1:0]            rld_q, rld_d;
  logic                          ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  always_comb begin
    ps_d       = ps_q;
    cnt_d      = cnt_q;
    en_d       = en_q;
    rld_d      = rld_q;
    cmd_ld_ps  = '0;
    cmd_ld_cnt = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      field_t fld;
      fld = field_t'(wr_data[i*FIELD_STRIDE +: FIELD_W]);
      if (ctrl_wr) begin
        en_d[i]       = fld.en;
        rld_d[i]      = fld.rld;
        cmd_ld_ps[i]  = fld.ld_ps;
        cmd_ld_cnt[i] = fld.ld_cnt;
      end
      if (wr_en && (wr_addr == ADDR_W'(1 + 2*i))) ps_d[i]  = wr_data[PS_W-1:0];
      if (wr_en && (wr_addr == ADDR_W'(2 + 2*i))) cnt_d[i] = wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      cnt_q <= '0;
      en_q  <= '0;
      rld_q <= '0;
    end else begin
      ps_q  <= ps_d;
      cnt_q <= cnt_d;
      en_q  <= en_d;
      rld_q <= rld_d;
    end
  end

  assign ps_pre   = ps_q;
  assign cnt_pre  = cnt_q;
  assign mode_en  = en_q;
  assign mode_rld = rld_q;
endmodule

// File: rtl/dtt_timer.sv
module dtt_timer #(
  parameter int PS_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rld,
  input  logic             ld_ps,
  input  logic             ld_cnt,
  input  logic [PS_W-1:0]  ps_pre,
  input  logic [CNT_W-1:0] cnt_pre,
  output logic [CNT_W-1:0] count,
  output logic             tick
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PS_W-1:0]  ps_q,  ps_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_q, tick_d;
  logic             active, ps_wrap, step;

  assign active  = en && (cnt_q != '0);
  assign ps_wrap = active && (ps_q == '0);
  assign step    = ps_wrap && !ld_ps;

  always_comb begin
    ps_d = ps_q;
    if (ld_ps)        ps_d = ps_pre;
    else if (ps_wrap) ps_d = ps_pre;
    else if (active)  ps_d = ps_q - 1'b1;
  end

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (ld_cnt) begin
      cnt_d = cnt_pre;
    end else if (step) begin
      if (cnt_q == CNT_ONE) begin
        tick_d = 1'b1;
        cnt_d  = rld ? cnt_pre : '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q   <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      ps_q   <= ps_d;
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign count = cnt_q;
  assign tick  = tick_q;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int PS_W   = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  gp_count,
  output logic [CNT_W-1:0]  rtc_count,
  output logic              gp_tick,
  output logic              rtc_tick
);
  logic                          rst_q_n;
  logic [NUM_TMR-1:0][PS_W-1:0]  ps_pre;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_pre;
  logic [NUM_TMR-1:0]            mode_en, mode_rld, cmd_ld_ps, cmd_ld_cnt;
  logic [NUM_TMR-1:0][CNT_W-1:0] count;
  logic [NUM_TMR-1:0]            tick;

  dtt_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  dtt_regfile #(.PS_W(PS_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ps_pre     (ps_pre),
    .cnt_pre    (cnt_pre),
    .mode_en    (mode_en),
    .mode_rld   (mode_rld),
    .cmd_ld_ps  (cmd_ld_ps),
    .cmd_ld_cnt (cmd_ld_cnt)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dtt_timer #(.PS_W(PS_W), .CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .en      (mode_en[g]),
      .rld     (mode_rld[g]),
      .ld_ps   (cmd_ld_ps[g]),
      .ld_cnt  (cmd_ld_cnt[g]),
      .ps_pre  (ps_pre[g]),
      .cnt_pre (cnt_pre[g]),
      .count   (count[g]),
      .tick    (tick[g])
    );
  end

  assign gp_count  = count[0];
  assign rtc_count = count[1];
  assign gp_tick   = tick[0];
  assign rtc_tick  = tick[1];
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  gp_count,
  input logic [CNT_W-1:0]  rtc_count,
  input logic              gp_tick,
  input logic              rtc_tick
);
  logic [1:0][CNT_W-1:0] cnt;
  logic [1:0]            tk;
  logic [1:0][CNT_W-1:0] pre_m;
  logic [1:0]            en_m;
  logic                  ctrl_wr;

  assign cnt     = {rtc_count, gp_count};
  assign tk      = {rtc_tick, gp_tick};
  assign ctrl_wr = wr_en && (wr_addr == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_m <= '0;
      en_m  <= '0;
    end else begin
      if (ctrl_wr) en_m <= {wr_data[10], wr_data[2]};
      if (wr_en && wr_addr == 3'd2) pre_m[0] <= wr_data[CNT_W-1:0];
      if (wr_en && wr_addr == 3'd4) pre_m[1] <= wr_data[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_TICK_FROM_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      tk[g] |-> $past(cnt[g]) == CNT_W'(1));  // R5
    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[g] == '0 && !(ctrl_wr && wr_data[g*8+1])) |=> cnt[g] == '0);  // R6
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_m[g] && !(ctrl_wr && wr_data[g*8+1])) |=> $stable(cnt[g]));  // R8
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wr_data[g*8+1]) |=> cnt[g] == $past(pre_m[g]));  // R9
  end
endmodule

bind dual_tick_timer dtt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .gp_count  (gp_count),
  .rtc_count (rtc_count),
  .gp_tick   (gp_tick),
  .rtc_tick  (rtc_tick)
);

// File: tb/sim_dual_tick_timer.sv
module sim_dual_tick_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PS_W = 4, CNT_W = 8, DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CNT_W-1:0]  gp_count, rtc_count;
  logic              gp_tick, rtc_tick;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tick_timer #(.PS_W(PS_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .gp_count(gp_count), .rtc_count(rtc_count), .gp_tick(gp_tick), .rtc_tick(rtc_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge.
  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(input bit rtc, input int maxn, output int n);
    n = -1;
    for (int k = 1; k <= maxn; k++) begin
      @(negedge clk);
      if ((rtc ? rtc_tick : gp_tick) && n < 0) begin n = k; break; end
    end
  endtask

  task automatic t_reset();
    check("R1 gp_count", gp_count, 0);
    check("R1 rtc_count", rtc_count, 0);
    check("R1 ticks", {gp_tick, rtc_tick}, 0);
    repeat (5) @(negedge clk);
    check("R1 disabled stays idle", gp_count + rtc_count, 0);
  endtask

  task automatic t_oneshot();
    int n, sum;
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h000E);
    check("R2 R9 gp counter loaded", gp_count, 3);
    wait_tick(1'b0, 100, n);
    check("R4 R3 gp first tick edge", n, 9);
    check("R6 count at tick", gp_count, 0);
    @(negedge clk);
    check("R5 tick width", gp_tick, 0);
    sum = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      sum += gp_tick;
    end
    check("R6 no tick after stop", sum, 0);
    check("R6 count held at zero", gp_count, 0);
  endtask

  task automatic t_reload();
    int n;
    wr(3'd3, 16'd1);
    wr(3'd4, 16'd4);
    wr(3'd0, 16'h0F00);
    check("R3 rtc counter loaded", rtc_count, 4);
    wait_tick(1'b1, 100, n);
    check("R4 rtc first tick edge", n, 8);
    check("R7 reload on tick edge", rtc_count, 4);
    wait_tick(1'b1, 100, n);
    check("R7 reload period", n, 8);
    wr(3'd0, 16'h0000);
  endtask

  task automatic t_hold();
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd20);
    wr(3'd0, 16'h000E);
    repeat (5) @(negedge clk);
    check("R4 step per edge", gp_count, 15);
    wr(3'd0, 16'h0000);
    check("R8 disable acts after write", gp_count, 14);
    repeat (20) @(negedge clk);
    check("R8 held while disabled", gp_count, 14);
    wr(3'd0, 16'h0004);
    check("R8 enable acts after write", gp_count, 14);
    repeat (3) @(negedge clk);
    check("R8 resumes", gp_count, 11);
  endtask

  task automatic t_load();
    wr(3'd2, 16'd50);
    check("R2 preset write keeps count", gp_count, 10);
    wr(3'd0, 16'h0006);
    check("R9 load overrides decrement", gp_count, 50);
    wr(3'd0, 16'h0004);
    check("R9 no load without bit", gp_count, 49);
  endtask

  task automatic t_indep();
    int v;
    wr(3'd3, 16'd3);
    wr(3'd4, 16'd7);
    wr(3'd2, 16'd200);
    wr(3'd0, 16'h000F);
    repeat (3) @(negedge clk);
    v = gp_count;
    check("R7 gp reload run", v, 197);
    wr(3'd0, 16'h0E05);
    check("R10 gp undisturbed", gp_count, v - 1);
    check("R10 rtc loaded", rtc_count, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_oneshot();
    t_reload();
    t_hold();
    t_load();
    t_indep();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule